// File: doc/BRIEF.md
# Opponent Order Shuffler

This block produces a random ordering of the opponent identifiers 1 to N for a turn-based matchup game. The default is N = 4. A free-running counter is sampled when a shuffle is accepted, and that value seeds a maximal-length linear feedback shift register (LFSR). The LFSR then supplies one index per step to a Fisher-Yates swap loop over an N-entry array. The result is always a true permutation, never a set of independent draws.

A shuffle starts by itself after every reset. The game controller can also ask for one at any later time. A `start_i` pulse reloads the array as 1..N and then shuffles it. A `reshuffle_i` pulse permutes the order that is already held, for use after a matchup result. `done_o` marks the cycle in which a new order is complete. The order then stays unchanged until the next accepted request.

Top module: `opp_order_shuffler`

## Requirements
- R1: After reset is released, the block runs a shuffle of the identity order without any request. `done_o` is high in the cycle that follows the fourth rising edge after release. The seed is taken from the counter value 0.
- R2: A request is accepted on a clock edge while the block is idle. `done_o` is high for exactly one cycle: the cycle that follows the (N-1)th rising edge after the accepting edge. `done_o` is low at every other time.
- R3: At every time outside reset, `order_o` holds a permutation of 1..N. Slot k is in bits [3k+2:3k], and slot 0 is in the lowest bits.
- R4: The seed is the value of an 8-bit counter at the accepting edge. The counter is 0 on the first edge after reset and increases by one on every edge, wrapping modulo 256. A seed of 0 is replaced by 0xA5.
- R5: The LFSR advances by one step per swap. It shifts its value left by one bit, and the new bit 0 is the XOR of bits 7, 5, 4 and 3, which is the polynomial x^8+x^6+x^5+x^4+1.
- R6: Steps run for i = N-1 down to 1, one per clock. Each step computes j = (LFSR value before that step's advance) mod (i+1) and exchanges slots i and j.
- R7: An accepted `start_i` first reloads slot k with the identifier k+1, and then shuffles that identity order.
- R8: An accepted `reshuffle_i` alone shuffles the order currently held, without reloading it.
- R9: When `start_i` and `reshuffle_i` are high on the same accepting edge, `start_i` wins and the identity order is shuffled.
- R10: Requests sampled while a shuffle is in progress have no effect on the result or on the timing of `done_o`.
- R11: While the block is idle and no request is present, `order_o` does not change.
- R12: While reset is asserted, `order_o` is the identity order and `done_o` is low. This also holds when reset arrives in the middle of a shuffle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Reload the identity order and shuffle it |
| reshuffle_i | input | 1 | Shuffle the order currently held |
| order_o | output | 12 | N slots of 3 bits each, slot 0 in the lowest bits |
| done_o | output | 1 | One-cycle pulse when a new order is ready |

## Verification
The bench builds the block with its default values: four slots, an 8-bit LFSR with taps 0xB8, and substitute seed 0xA5. At this size a start can be issued at every one of the 256 counter values. The bench can therefore compare every possible seed, including the substituted zero, against an arithmetic model of the swap loop and confirm that each result is a permutation. Chained reshuffles, simultaneous requests, requests during the swap steps and a reset in the middle of a shuffle cover the remaining ordering and priority cases.

// File: rtl/shuf_pkg.sv
// Shared types for the opponent order shuffler.
// Assumes: none; holds only the control state encoding.
package shuf_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SWAP = 1'b1
    } shuf_state_e;

endpackage

// File: rtl/shuf_seed_ctr.sv
// Free-running counter whose value seeds each shuffle.
// Assumes: it is cleared by reset and wraps naturally at 2**W.
module shuf_seed_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count_o
);

    // Advance the counter once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) count_o <= '0;
        else        count_o <= count_o + 1'b1;
    end

    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count_o == $past(count_o) + 1'b1); // R4

endmodule

// File: rtl/shuf_lfsr.sv
// Left-shifting Fibonacci LFSR with a seed load and zero-seed substitution.
// Assumes: TAPS describes a primitive polynomial and ZERO_SUB is nonzero.
module shuf_lfsr #(
    parameter int           W        = 8,
    parameter logic [W-1:0] TAPS     = 8'hB8,
    parameter logic [W-1:0] ZERO_SUB = 8'hA5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] seed_i,
    input  logic         adv_i,
    output logic [W-1:0] value_o
);

    logic feedback;

    // XOR of the tapped bits forms the new low bit.
    always_comb feedback = ^(value_o & TAPS);

    // Load a seed (never zero) or advance by one step.
    always_ff @(posedge clk) begin
        if (!rst_n)      value_o <= ZERO_SUB;
        else if (load_i) value_o <= (seed_i == '0) ? ZERO_SUB : seed_i;
        else if (adv_i)  value_o <= {value_o[W-2:0], feedback};
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        value_o != '0); // R5

    AST_LFSR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !load_i) |=> value_o[W-1:1] == $past(value_o[W-2:0])); // R5

    AST_SEED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i != '0) |=> value_o == $past(seed_i)); // R4

    AST_ZERO_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && seed_i == '0) |=> value_o == ZERO_SUB); // R4

endmodule

// File: rtl/shuf_index.sv
// Reduces an LFSR value to a swap partner index in the range 0..bound.
// Assumes: bound_i + 1 fits in W bits, so the divisor is never zero.
module shuf_index #(
    parameter int W     = 8,
    parameter int IDX_W = 2
) (
    input  logic [W-1:0]     value_i,
    input  logic [IDX_W-1:0] bound_i,
    output logic [IDX_W-1:0] idx_o
);

    logic [W-1:0] divisor;

    // Divisor is the count of slots still open at this step.
    always_comb divisor = W'(bound_i) + W'(1);

    // Remainder selects the partner slot.
    always_comb idx_o = IDX_W'(value_i % divisor);

endmodule

// File: rtl/opp_order_shuffler.sv
// Top level: holds the N-slot order and sequences the Fisher-Yates steps.
// Assumes: N_SLOTS is a power of two, at least 2, so slot indices cover the array.
module opp_order_shuffler
    import shuf_pkg::*;
#(
    parameter int                N_SLOTS       = 4,
    parameter int                LFSR_W        = 8,
    parameter logic [LFSR_W-1:0] LFSR_TAPS     = 8'hB8,
    parameter logic [LFSR_W-1:0] ZERO_SEED_SUB = 8'hA5,
    localparam int               ID_W          = $clog2(N_SLOTS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic                      reshuffle_i,
    output logic [N_SLOTS*ID_W-1:0]   order_o,
    output logic                      done_o
);

    localparam int STEP_W = $clog2(N_SLOTS);
    localparam int MASK_W = 2 ** ID_W;
    localparam logic [MASK_W-1:0] FULL_MASK = MASK_W'((1 << (N_SLOTS + 1)) - 2);

    logic [LFSR_W-1:0] ctr_val;
    logic [LFSR_W-1:0] lfsr_val;
    logic [STEP_W-1:0] step_q;
    logic [STEP_W-1:0] pick_idx;
    logic [ID_W-1:0]   slot_q [N_SLOTS];
    shuf_state_e       state_q;
    logic              boot_q;
    logic              done_q;
    logic              trig, accept, reload, swapping, last_step;
    logic [MASK_W-1:0] seen;

    // Request decode: a pending boot shuffle behaves like a start.
    always_comb begin
        trig      = boot_q | start_i | reshuffle_i;
        accept    = (state_q == ST_IDLE) & trig;
        reload    = boot_q | start_i;
        swapping  = (state_q == ST_SWAP);
        last_step = (step_q == STEP_W'(1));
    end

    shuf_seed_ctr #(.W(LFSR_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (ctr_val)
    );

    shuf_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .ZERO_SUB(ZERO_SEED_SUB)) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .seed_i  (ctr_val),
        .adv_i   (swapping),
        .value_o (lfsr_val)
    );

    shuf_index #(.W(LFSR_W), .IDX_W(STEP_W)) u_idx (
        .value_i (lfsr_val),
        .bound_i (step_q),
        .idx_o   (pick_idx)
    );

    // Control: accept a request, count the steps down, pulse done at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            boot_q  <= 1'b1;
            done_q  <= 1'b0;
            step_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_SWAP;
                        boot_q  <= 1'b0;
                        step_q  <= STEP_W'(N_SLOTS - 1);
                    end
                end
                default: begin
                    if (last_step) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end else begin
                        step_q <= step_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // One storage process per slot: reload, or take part in the current swap.
    for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[k] <= ID_W'(k + 1);
            end else if (accept && reload) begin
                slot_q[k] <= ID_W'(k + 1);
            end else if (swapping) begin
                if (STEP_W'(k) == step_q)        slot_q[k] <= slot_q[pick_idx];
                else if (STEP_W'(k) == pick_idx) slot_q[k] <= slot_q[step_q];
            end
        end
        assign order_o[k*ID_W +: ID_W] = slot_q[k];
    end

    assign done_o = done_q;

    // Mark which identifiers are present, for the permutation check.
    always_comb begin
        seen = '0;
        for (int k = 0; k < N_SLOTS; k++) seen[slot_q[k]] = 1'b1;
    end

    AST_IS_PERM: assert property (@(posedge clk) disable iff (!rst_n)
        seen == FULL_MASK); // R3

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2

    AST_DONE_FROM_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(state_q == ST_SWAP)); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !trig) |=> $stable(order_o)); // R11

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (swapping && !last_step) |=> state_q == ST_SWAP); // R10

endmodule

// File: tb/tb_opp_order_shuffler.sv
module tb_opp_order_shuffler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        reshuffle_i = 1'b0;
    logic [11:0] order_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    logic [7:0]  bc;
    logic [11:0] snap;

    localparam logic [11:0] ID = {3'd4, 3'd3, 3'd2, 3'd1};

    opp_order_shuffler dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .reshuffle_i (reshuffle_i),
        .order_o     (order_o),
        .done_o      (done_o)
    );

    always #5 clk = ~clk;

    // Bench copy of the seed counter as specified in R4.
    always @(posedge clk) begin
        if (!rst_n) bc <= 8'd0;
        else        bc <= bc + 8'd1;
    end

    function automatic logic [11:0] model(input logic [11:0] base, input logic [7:0] seed);
        logic [2:0] s [4];
        logic [2:0] t;
        logic [7:0] l;
        for (int k = 0; k < 4; k++) s[k] = base[k*3 +: 3];
        l = (seed == 8'd0) ? 8'hA5 : seed;
        for (int i = 3; i >= 1; i--) begin
            int j;
            j = int'(l) % (i + 1);
            t = s[i]; s[i] = s[j]; s[j] = t;
            l = {l[6:0], l[7] ^ l[5] ^ l[4] ^ l[3]};
        end
        return {s[3], s[2], s[1], s[0]};
    endfunction

    function automatic bit is_perm(input logic [11:0] v);
        logic [7:0] m;
        m = '0;
        for (int k = 0; k < 4; k++) m[v[k*3 +: 3]] = 1'b1;
        return m == 8'b0001_1110;
    endfunction

    task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cnt(input logic [7:0] v);
        while (bc != v) @(negedge clk);
    endtask

    // Issue a request at the current negedge and check the result and the done timing.
    task automatic shuffle(input bit s, input bit r, input logic [11:0] base, input string req);
        logic [11:0] exp;
        exp = model(base, bc);
        start_i = s; reshuffle_i = r;
        @(negedge clk);
        start_i = 1'b0; reshuffle_i = 1'b0;
        repeat (2) @(negedge clk);
        check(done_o == 1'b0, "R2 early done", {11'd0, done_o}, 12'd0);
        @(negedge clk);
        check(done_o == 1'b1, "R2 done timing", {11'd0, done_o}, 12'd1);
        check(order_o == exp, req, order_o, exp);
        check(is_perm(order_o), "R3 permutation", order_o, exp);
        @(negedge clk);
        check(done_o == 1'b0, "R2 single pulse", {11'd0, done_o}, 12'd0);
    endtask

    task automatic boot_check(input string tag);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(done_o == 1'b0, "R1 boot early", {11'd0, done_o}, 12'd0);
        @(negedge clk);
        check(done_o == 1'b1, "R1 boot done", {11'd0, done_o}, 12'd1);
        check(order_o == model(ID, 8'd0), tag, order_o, model(ID, 8'd0));
        check(order_o == model(ID, 8'hA5), "R4 zero seed substitute", order_o, model(ID, 8'hA5));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s1;
        bit         moved;
        repeat (3) @(negedge clk);
        check(done_o == 1'b0 && order_o == ID, "R12 reset state", order_o, ID);
        boot_check("R1 boot order");

        // R4 R6 R7: start at every counter value
        for (int v = 0; v < 256; v++) begin
            wait_cnt(v[7:0]);
            shuffle(1'b1, 1'b0, ID, "R6 R7 start seed sweep");
        end

        // R8: chained reshuffles of the held order
        for (int k = 0; k < 24; k++) begin
            repeat (k % 3) @(negedge clk);
            shuffle(1'b0, 1'b1, order_o, "R8 reshuffle chain");
        end

        // R9: simultaneous requests, start wins
        shuffle(1'b1, 1'b1, ID, "R9 start priority");

        // R10: requests during the swap steps are ignored
        s1 = bc;
        start_i = 1'b1;
        @(negedge clk);
        reshuffle_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(done_o == 1'b0, "R10 busy early done", {11'd0, done_o}, 12'd0);
        @(negedge clk);
        start_i = 1'b0; reshuffle_i = 1'b0;
        check(done_o == 1'b1, "R10 busy done timing", {11'd0, done_o}, 12'd1);
        check(order_o == model(ID, s1), "R10 busy result", order_o, model(ID, s1));
        snap = order_o;
        moved = 1'b0;
        repeat (4) begin
            @(negedge clk);
            if (done_o || order_o != snap) moved = 1'b1;
        end
        check(!moved, "R10 no hidden shuffle", order_o, snap);

        // R11: idle hold
        snap = order_o;
        moved = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (order_o != snap) moved = 1'b1;
        end
        check(!moved, "R11 idle hold", order_o, snap);

        // R12: reset in the middle of a shuffle
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(done_o == 1'b0 && order_o == ID, "R12 reset mid shuffle", order_o, ID);
        boot_check("R1 boot after second reset");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule